// File: doc/BRIEF.md
# Power-Up Register Restore Sequencer

This block refills the volatile working registers of a four-channel DAC from a five-entry nonvolatile array once reset is released. Four entries hold 8-bit channel codes. The fifth holds an 8-bit operating-mode word: its upper nibble mutes channels and its lower nibble shuts them down. The block reads the array through a synchronous port with one cycle of latency. A local slot timer spaces the reads, so the whole restore takes a parameterised number of clock cycles. That count is chosen to match the required restore time at the system clock.

While the restore runs, the block forces every channel output muted and tells the serial command front end to ignore its pins. The mode word is fetched last. The cycle it lands, the forced mute and the interface lock both release, and a one-cycle completion pulse is raised. A synchronous rerun request behaves like a fresh power-up: it zeroes every working register and repeats the whole sequence.

Top module: `nv_restore_seq`

## Requirements
- R1: While `rst_n` is low, all channel codes and the mode word read zero, `mem_rd_en_o` and `done_o` are low, and `init_active_o`, `hold_mute_o` and `if_disable_o` are high.
- R2: One restore issues exactly five read strobes, each one cycle wide, with addresses in the order 0, 1, 2, 3, 4.
- R3: Data returned one cycle after a strobe at address i (0 to 3) is written to channel i's code, bits [8i+7:8i] of `dac_code_o`; data returned for address 4 is written to `mode_o`.
- R4: The mode word is restored last. `mode_o` keeps its cleared value until the cycle in which `done_o` is high.
- R5: From reset until completion, `init_active_o`, `hold_mute_o` and `if_disable_o` are high and `eff_mute_o` is all ones.
- R6: After completion, bit i of `eff_mute_o` equals bit 4+i of the restored mode word, and `dac_code_o` shows the restored codes.
- R7: `done_o` is a single-cycle pulse. When `TOTAL_CYC` is a multiple of five, it is high after exactly `TOTAL_CYC` rising edges counted from the first edge with reset released, and `init_active_o` falls in that same cycle.
- R8: A `rerun_i` sampled high zeroes every code and the mode word at that edge. It then restarts the sequence, and completion comes `TOTAL_CYC` edges after that edge.
- R9: After completion, no further reads are issued and the codes stay stable until the next rerun or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rerun_i | input | 1 | Synchronous request to clear the working registers and restore again |
| mem_rd_en_o | output | 1 | Read strobe to the nonvolatile array |
| mem_addr_o | output | 3 | Entry address: 0 to 3 for codes, 4 for the mode word |
| mem_rd_data_i | input | 8 | Read data, valid one cycle after the strobe |
| dac_code_o | output | 32 | Working channel codes, channel i at [8i+7:8i] |
| mode_o | output | 8 | Working mode word: [7:4] mute, [3:0] shutdown |
| eff_mute_o | output | 4 | Effective per-channel mute seen by the output stage |
| hold_mute_o | output | 1 | Forces all channel outputs muted |
| if_disable_o | output | 1 | Locks the serial command interface |
| init_active_o | output | 1 | Restore in progress |
| done_o | output | 1 | One-cycle pulse when the mode word lands |

## Verification
The assertions assume that the array answers every strobe one cycle later and never by itself. They also assume that `rerun_i` is an isolated one-cycle request and is not held across consecutive edges. The bench's memory model answers only on strobes. Its stimulus raises rerun for exactly one cycle and only after the previous restore has completed. Each pattern fills the array with distinct codes and mode words, so that a wrong address order or a write into the wrong lane shows up at the outputs.

// File: rtl/nvr_pkg.sv
package nvr_pkg;
  typedef enum logic [1:0] {
    ST_PACE = 2'd0,
    ST_READ = 2'd1,
    ST_LAND = 2'd2,
    ST_DONE = 2'd3
  } nvr_state_e;
endpackage

// File: rtl/nvr_pace_timer.sv
module nvr_pace_timer #(
  parameter int SLOT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int CW = $clog2(SLOT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign expired_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i && !expired_o) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/nvr_seq_fsm.sv
module nvr_seq_fsm
  import nvr_pkg::*;
#(
  parameter int NUM_DAC = 4,
  parameter int AW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rerun_i,
  input  logic          slot_expired_i,
  output logic          slot_clr_o,
  output logic          slot_en_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          cap_en_o,
  output logic [AW-1:0] cap_idx_o,
  output logic          active_o,
  output logic          done_o
);
  localparam logic [AW-1:0] MODE_IDX = AW'(NUM_DAC);

  nvr_state_e    state_q, state_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_PACE: if (slot_expired_i) state_d = ST_READ;
      ST_READ: state_d = ST_LAND;
      ST_LAND: begin
        if (idx_q == MODE_IDX) begin
          state_d = ST_DONE;
          done_d  = 1'b1;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_PACE;
        end
      end
      default: state_d = ST_DONE;
    endcase
    if (rerun_i) begin
      state_d = ST_PACE;
      idx_d   = '0;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PACE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign slot_en_o  = (state_q == ST_PACE);
  assign slot_clr_o = (state_q != ST_PACE) || rerun_i;
  assign rd_en_o    = (state_q == ST_READ) && !rerun_i;
  assign rd_addr_o  = idx_q;
  assign cap_en_o   = (state_q == ST_LAND);
  assign cap_idx_o  = idx_q;
  assign active_o   = (state_q != ST_DONE);
  assign done_o     = done_q;
endmodule

// File: rtl/nvr_work_regs.sv
module nvr_work_regs #(
  parameter int NUM_DAC = 4,
  parameter int DW      = 8,
  parameter int AW      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  cap_en_i,
  input  logic [AW-1:0]         cap_idx_i,
  input  logic [DW-1:0]         cap_data_i,
  output logic [NUM_DAC*DW-1:0] codes_o,
  output logic [DW-1:0]         mode_o
);
  localparam logic [AW-1:0] MODE_IDX = AW'(NUM_DAC);

  for (genvar g = 0; g < NUM_DAC; g++) begin : g_lane
    logic [DW-1:0] code_q, code_d;
    logic          load_en;

    assign load_en = cap_en_i && (cap_idx_i == AW'(g));

    always_comb begin
      code_d = code_q;
      if (clear_i) begin
        code_d = '0;
      end else if (load_en) begin
        code_d = cap_data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q <= '0;
      end else begin
        code_q <= code_d;
      end
    end

    assign codes_o[g*DW +: DW] = code_q;
  end

  logic [DW-1:0] mode_q, mode_d;
  logic          mode_load_en;

  assign mode_load_en = cap_en_i && (cap_idx_i == MODE_IDX);

  always_comb begin
    mode_d = mode_q;
    if (clear_i) begin
      mode_d = '0;
    end else if (mode_load_en) begin
      mode_d = cap_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/nv_restore_seq.sv
module nv_restore_seq #(
  parameter int NUM_DAC   = 4,
  parameter int DW        = 8,
  parameter int TOTAL_CYC = 20000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rerun_i,
  output logic                                mem_rd_en_o,
  output logic [$clog2(NUM_DAC+1)-1:0]        mem_addr_o,
  input  logic [DW-1:0]                       mem_rd_data_i,
  output logic [NUM_DAC*DW-1:0]               dac_code_o,
  output logic [DW-1:0]                       mode_o,
  output logic [NUM_DAC-1:0]                  eff_mute_o,
  output logic                                hold_mute_o,
  output logic                                if_disable_o,
  output logic                                init_active_o,
  output logic                                done_o
);
  localparam int NUM_ENTRIES = NUM_DAC + 1;
  localparam int AW          = $clog2(NUM_ENTRIES);
  localparam int SLOT_CYC    = TOTAL_CYC / NUM_ENTRIES - 2;

  logic          slot_expired;
  logic          slot_clr;
  logic          slot_en;
  logic          cap_en;
  logic [AW-1:0] cap_idx;
  logic          active;

  nvr_pace_timer #(
    .SLOT_CYC (SLOT_CYC)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (slot_clr),
    .en_i      (slot_en),
    .expired_o (slot_expired)
  );

  nvr_seq_fsm #(
    .NUM_DAC (NUM_DAC),
    .AW      (AW)
  ) fsm_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rerun_i        (rerun_i),
    .slot_expired_i (slot_expired),
    .slot_clr_o     (slot_clr),
    .slot_en_o      (slot_en),
    .rd_en_o        (mem_rd_en_o),
    .rd_addr_o      (mem_addr_o),
    .cap_en_o       (cap_en),
    .cap_idx_o      (cap_idx),
    .active_o       (active),
    .done_o         (done_o)
  );

  nvr_work_regs #(
    .NUM_DAC (NUM_DAC),
    .DW      (DW),
    .AW      (AW)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (rerun_i),
    .cap_en_i   (cap_en),
    .cap_idx_i  (cap_idx),
    .cap_data_i (mem_rd_data_i),
    .codes_o    (dac_code_o),
    .mode_o     (mode_o)
  );

  assign init_active_o = active;
  assign hold_mute_o   = active;
  assign if_disable_o  = active;
  assign eff_mute_o    = active ? {NUM_DAC{1'b1}} : mode_o[DW-1 -: NUM_DAC];
endmodule

// File: rtl/nvr_restore_chk.sv
module nvr_restore_chk #(
  parameter int NUM_DAC = 4,
  parameter int DW      = 8,
  parameter int AW      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rerun_i,
  input logic                  mem_rd_en_o,
  input logic [AW-1:0]         mem_addr_o,
  input logic [NUM_DAC*DW-1:0] dac_code_o,
  input logic [DW-1:0]         mode_o,
  input logic [NUM_DAC-1:0]    eff_mute_o,
  input logic                  hold_mute_o,
  input logic                  if_disable_o,
  input logic                  init_active_o,
  input logic                  done_o
);
  logic [AW-1:0] exp_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_addr_q <= '0;
    end else if (rerun_i) begin
      exp_addr_q <= '0;
    end else if (mem_rd_en_o) begin
      exp_addr_q <= exp_addr_q + 1'b1;
    end
  end

  AST_RD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |-> mem_addr_o == exp_addr_q) else $error("read order");  // R2
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |=> !mem_rd_en_o) else $error("read strobe width");  // R2
  AST_MODE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !$past(rerun_i)) |-> $stable(mode_o)) else $error("mode early");  // R4
  AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    init_active_o |-> (hold_mute_o && if_disable_o && (&eff_mute_o))) else $error("hold");  // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done width");  // R7
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!init_active_o && $past(init_active_o))) else $error("done edge");  // R7
  AST_RERUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rerun_i) |-> (dac_code_o == '0 && mode_o == '0)) else $error("rerun clear");  // R8
  AST_NO_LATE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !init_active_o |-> !mem_rd_en_o) else $error("late read");  // R9
  AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_active_o && $past(!init_active_o)) |-> $stable(dac_code_o)) else $error("codes moved");  // R9
endmodule

bind nv_restore_seq nvr_restore_chk #(
  .NUM_DAC (NUM_DAC),
  .DW      (DW),
  .AW      ($clog2(NUM_DAC+1))
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .rerun_i       (rerun_i),
  .mem_rd_en_o   (mem_rd_en_o),
  .mem_addr_o    (mem_addr_o),
  .dac_code_o    (dac_code_o),
  .mode_o        (mode_o),
  .eff_mute_o    (eff_mute_o),
  .hold_mute_o   (hold_mute_o),
  .if_disable_o  (if_disable_o),
  .init_active_o (init_active_o),
  .done_o        (done_o)
);

// File: tb/nv_restore_seq_tb_top.sv
module nv_restore_seq_tb_top;
  localparam int TOTAL = 60;

  logic        clk;
  logic        rst_n;
  logic        rerun_i;
  logic        mem_rd_en_o;
  logic [2:0]  mem_addr_o;
  logic [7:0]  mem_rd_data_i;
  logic [31:0] dac_code_o;
  logic [7:0]  mode_o;
  logic [3:0]  eff_mute_o;
  logic        hold_mute_o;
  logic        if_disable_o;
  logic        init_active_o;
  logic        done_o;

  nv_restore_seq #(.NUM_DAC(4), .DW(8), .TOTAL_CYC(TOTAL)) dut_i (
    .clk (clk), .rst_n (rst_n), .rerun_i (rerun_i),
    .mem_rd_en_o (mem_rd_en_o), .mem_addr_o (mem_addr_o), .mem_rd_data_i (mem_rd_data_i),
    .dac_code_o (dac_code_o), .mode_o (mode_o), .eff_mute_o (eff_mute_o),
    .hold_mute_o (hold_mute_o), .if_disable_o (if_disable_o),
    .init_active_o (init_active_o), .done_o (done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // stimulus/expected vectors: {expected mute nibble, mode, code3, code2, code1, code0}
  localparam logic [43:0] VEC [4] = '{
    44'h0_0078563412,
    44'hA_A50180FF00,
    44'hF_F0FFFFFFFF,
    44'h3_3EF00FC33C
  };

  logic [7:0] mem [5];
  logic [2:0] rd_log [8];
  int         rd_cnt;
  int         n_tests;
  int         n_fail;
  bit         finished;

  always @(posedge clk) begin
    if (mem_rd_en_o) begin
      mem_rd_data_i <= mem[mem_addr_o];
      if (rd_cnt < 8) rd_log[rd_cnt] <= mem_addr_o;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_mem(input logic [39:0] v);
    for (int i = 0; i < 5; i++) mem[i] = v[i*8 +: 8];
  endtask

  // waits until just after edge (start + k), counting from the negedge after start
  task automatic wait_neg(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    n_tests = 0; n_fail = 0; finished = 1'b0;
    rd_cnt = 0; rerun_i = 1'b0; mem_rd_data_i = '0;
    rst_n = 1'b0;
    load_mem(VEC[0][39:0]);
    wait_neg(3);
    // R1: reset state
    check(dac_code_o == 0 && mode_o == 0, "R1 regs zero", {mode_o, dac_code_o}, 0);
    check(!mem_rd_en_o && !done_o, "R1 no strobe/done", {mem_rd_en_o, done_o}, 0);
    check(init_active_o && hold_mute_o && if_disable_o, "R1 hold flags",
          {init_active_o, hold_mute_o, if_disable_o}, 3'b111);
    rst_n = 1'b1;              // released at a negedge: next posedge is edge 1
    wait_neg(12);              // after edge 12: entry 0 landed
    check(dac_code_o[7:0] == mem[0] && dac_code_o[15:8] == 0, "R3 lane0 after reset",
          dac_code_o, {16'h0, mem[0]});
    wait_neg(47);              // after edge 59
    check(init_active_o && !done_o && mode_o == 0, "R4 mode held before end",
          {init_active_o, done_o, mode_o}, 10'h200);
    wait_neg(1);               // after edge 60
    check(done_o && !init_active_o, "R7 done after TOTAL edges from reset",
          {done_o, init_active_o}, 2'b10);
    check(dac_code_o == VEC[0][31:0] && mode_o == VEC[0][39:32], "R6 reset restore values",
          {mode_o, dac_code_o}, VEC[0][39:0]);

    for (int v = 0; v < 4; v++) begin
      load_mem(VEC[v][39:0]);
      wait_neg(3);
      rerun_i = 1'b1;
      rd_cnt  = 0;
      wait_neg(1);             // after rerun edge e
      rerun_i = 1'b0;
      check(dac_code_o == 0 && mode_o == 0 && init_active_o, "R8 rerun clears",
            {mode_o, dac_code_o}, 0);
      wait_neg(11);            // after edge e+11
      check(dac_code_o[7:0] == 0, "R3 lane0 not yet", dac_code_o[7:0], 0);
      wait_neg(1);             // after edge e+12
      check(dac_code_o[7:0] == VEC[v][7:0] && dac_code_o[31:8] == 0, "R3 lane0 landed",
            dac_code_o, {24'h0, VEC[v][7:0]});
      wait_neg(47);            // after edge e+59
      check(init_active_o && hold_mute_o && if_disable_o && eff_mute_o == 4'hF,
            "R5 held during restore", {init_active_o, hold_mute_o, if_disable_o, eff_mute_o}, 7'h7F);
      check(mode_o == 0 && dac_code_o == VEC[v][31:0], "R4 codes before mode",
            {mode_o, dac_code_o}, {8'h0, VEC[v][31:0]});
      wait_neg(1);             // after edge e+60
      check(done_o && !init_active_o && !hold_mute_o && !if_disable_o, "R7 done on time",
            {done_o, init_active_o, hold_mute_o, if_disable_o}, 4'b1000);
      check(mode_o == VEC[v][39:32], "R4 mode lands last", mode_o, VEC[v][39:32]);
      check(eff_mute_o == VEC[v][43:40], "R6 effective mute", eff_mute_o, VEC[v][43:40]);
      check(rd_cnt == 5 && rd_log[0] == 0 && rd_log[1] == 1 && rd_log[2] == 2 &&
            rd_log[3] == 3 && rd_log[4] == 4, "R2 read order", rd_cnt, 5);
      wait_neg(1);
      check(!done_o, "R7 done one cycle", done_o, 0);
      wait_neg(30);
      check(rd_cnt == 5 && dac_code_o == VEC[v][31:0], "R9 idle after done",
            {rd_cnt[7:0], dac_code_o}, {8'd5, VEC[v][31:0]});
    end
    finish_run();
  end
endmodule